// File: doc/BRIEF.md
# SPI Slave Register-Access Bridge

This block lets an external SPI master read and write registers on a simple on-chip parallel bus. The block has no clock input from the serial side. The serial clock, the active-low select and the MOSI line are all sampled by a much faster system clock and then synchronized. The design assumes a ratio of four system cycles per serial clock period. Serial edges are found inside the system domain.

The SPI mode uses an idle-low clock. The master launches on the rising edge and samples on the falling edge. Each frame has 32 bits, sent most significant bit first:

- a 16-bit header, whose top bit selects the operation (1 = read, 0 = write), followed by a 15-bit register address;
- a 16-bit data half.

For a write, the bridge issues a single strobe after the final data bit arrives. For a read, the bridge strobes the register file as soon as the header is complete. It takes the returned word one cycle later and shifts it out on MISO during the data half. This leaves no spare serial edge for the fetch.

Top module: `spi_reg_bridge`

## Requirements
- R1: MOSI is captured on each falling serial clock edge while select is low. The first 16 bits form the header, MSB first: header bit 15 is the command and bits 14..0 are the address. The next 16 bits are the data, MSB first.
- R2: In a write frame (command 0), `regWr` is high for exactly one system cycle after the 32nd bit is captured with select still low. In that cycle `regAddr` and `regWdata` carry the frame's address and data.
- R3: In a read frame (command 1), `regRd` is high for exactly one system cycle, in the cycle the 16th bit is captured, with `regAddr` valid in that cycle. A read frame never raises `regWr`, whatever its data half carries.
- R4: `regRdata` is sampled one system cycle after `regRd`. Its bits then appear on `misoOut` MSB first, one per data-half bit. Each bit is stable at the falling serial edge where the master samples it.
- R5: `misoOut` is 0 while select is high, during the whole header, and throughout write frames.
- R6: If select rises before 32 bits are captured, the frame is discarded: no `regWr` is issued and the bit count returns to zero.
- R7: After an aborted frame, the next select assertion starts again from bit 0 and decodes normally.
- R8: Serial clock edges while select is high, and edges beyond the 32nd within a frame, have no effect on the bus.
- R9: While `rstN` is low, `regWr`, `regRd` and `misoOut` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sckIn | input | 1 | Serial clock from the master, idle low |
| csNIn | input | 1 | Active-low frame select |
| mosiIn | input | 1 | Serial data from the master |
| misoOut | output | 1 | Serial data to the master |
| regAddr | output | 15 | Register address |
| regWdata | output | 16 | Write data, valid with `regWr` |
| regWr | output | 1 | One-cycle write strobe |
| regRd | output | 1 | One-cycle read strobe |
| regRdata | input | 16 | Read data, sampled the cycle after `regRd` |

## Verification
The tightest collision is between the read fetch and a frame abort. The bench provokes it by raising select right after the first data bit of a read frame. At that point the fetched word has just been loaded into the MISO shifter, and the select clear arrives within a few cycles. The bench then checks two things: MISO settles to 0 while select is high, and the following frame's header and write decode normally. A second overlap is the read strobe falling on the same serial edge as the last header bit. The scoreboard's monitor checks the address at exactly that strobe cycle, and the bench checks the returned bits at each falling serial edge.

// File: rtl/spi_bridge_pkg.sv
package spi_bridge_pkg;

  // Strobes from control to datapath, all valid within one system cycle.
  typedef struct packed {
    logic capture;    // shift one MOSI bit in
    logic latchAddr;  // header complete: hold command and address
    logic rdStb;      // read strobe to the register bus
    logic wrStb;      // write strobe to the register bus
    logic loadMiso;   // take returned read data into the MISO shifter
    logic shiftMiso;  // advance MISO to the next data bit
    logic clear;      // select inactive: flush frame state
  } ctrlStrobesT;

endpackage

// File: rtl/spi_bridge_sync.sv
module spi_bridge_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : gStage
    if (s == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[s] <= RST_VAL;
        else       chain[s] <= asyncIn;
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[s] <= RST_VAL;
        else       chain[s] <= chain[s-1];
      end
    end
  end

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/spi_bridge_ctrl.sv
module spi_bridge_ctrl
  import spi_bridge_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int DATA_W = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sckSync,
  input  logic        csNSync,
  input  logic        cmdNow,
  input  logic        cmdHeld,
  output ctrlStrobesT strobes
);

  localparam int FRAME_W = HALF_W + DATA_W;
  localparam int CNT_W = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] LAST_HDR = CNT_W'(HALF_W - 1);
  localparam logic [CNT_W-1:0] FIRST_DATA = CNT_W'(HALF_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(FRAME_W);

  logic             sckPrev;
  logic             csActive;
  logic             fallDet;
  logic             capture;
  logic             rdPend;
  logic [CNT_W-1:0] bitCnt;

  assign csActive = !csNSync;
  assign fallDet = csActive && sckPrev && !sckSync;
  assign capture = fallDet && (bitCnt < FULL_CNT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sckPrev <= 1'b0;
    else       sckPrev <= sckSync;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         bitCnt <= '0;
    else if (!csActive) bitCnt <= '0;
    else if (capture)  bitCnt <= bitCnt + 1'b1;
  end

  always_comb begin
    strobes = '0;
    strobes.clear     = !csActive;
    strobes.capture   = capture;
    strobes.latchAddr = capture && (bitCnt == LAST_HDR);
    strobes.rdStb     = capture && (bitCnt == LAST_HDR) && cmdNow;
    strobes.wrStb     = capture && (bitCnt == LAST_BIT) && !cmdHeld;
    strobes.loadMiso  = rdPend && csActive;
    strobes.shiftMiso = capture && (bitCnt >= FIRST_DATA);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdPend <= 1'b0;
    else       rdPend <= strobes.rdStb;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= FULL_CNT); // R8
  AST_CS_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    !csActive |=> bitCnt == '0); // R6
  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rdStb |=> !strobes.rdStb); // R3
  AST_LOAD_AFTER_RD: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadMiso |-> $past(strobes.rdStb)); // R4
  AST_WR_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrStb |=> bitCnt == FULL_CNT); // R2

endmodule

// File: rtl/spi_bridge_dp.sv
module spi_bridge_dp
  import spi_bridge_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobesT       strobes,
  input  logic              mosiBit,
  input  logic [DATA_W-1:0] rdData,
  output logic              cmdNow,
  output logic              cmdHeld,
  output logic [HALF_W-2:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  output logic              misoOut
);

  localparam int SR_W = (HALF_W > DATA_W) ? HALF_W : DATA_W;

  logic [SR_W-1:0]   inSr;
  logic [SR_W-1:0]   nextSr;
  logic [HALF_W-1:0] hdrHold;
  logic [DATA_W-1:0] misoSr;

  assign nextSr = {inSr[SR_W-2:0], mosiBit};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                inSr <= '0;
    else if (strobes.clear)   inSr <= '0;
    else if (strobes.capture) inSr <= nextSr;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  hdrHold <= '0;
    else if (strobes.clear)     hdrHold <= '0;
    else if (strobes.latchAddr) hdrHold <= nextSr[HALF_W-1:0];
  end

  // Command bit sits one below the header width until the last header bit lands.
  assign cmdNow = inSr[HALF_W-2];
  assign cmdHeld = hdrHold[HALF_W-1];

  // During a read strobe the address still includes the bit arriving now.
  assign regAddr = strobes.rdStb ? nextSr[HALF_W-2:0] : hdrHold[HALF_W-2:0];
  assign regWdata = nextSr[DATA_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  misoSr <= '0;
    else if (strobes.clear)     misoSr <= '0;
    else if (strobes.loadMiso)  misoSr <= rdData;
    else if (strobes.shiftMiso) misoSr <= {misoSr[DATA_W-2:0], 1'b0};
  end

  assign misoOut = misoSr[DATA_W-1];

  AST_MISO_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.clear) |-> !misoOut); // R5
  AST_MISO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobes.loadMiso) |-> misoOut == $past(rdData[DATA_W-1])); // R4

endmodule

// File: rtl/spi_reg_bridge.sv
module spi_reg_bridge
  import spi_bridge_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckIn,
  input  logic              csNIn,
  input  logic              mosiIn,
  output logic              misoOut,
  output logic [ADDR_W-1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  output logic              regWr,
  output logic              regRd,
  input  logic [DATA_W-1:0] regRdata
);

  localparam int HALF_W = ADDR_W + 1;

  logic [2:0]  syncVec;
  ctrlStrobesT strobes;
  logic        cmdNow;
  logic        cmdHeld;

  spi_bridge_sync #(
    .WIDTH(3),
    .STAGES(SYNC_STAGES),
    .RST_VAL(3'b010)
  ) uSync (
    .clk(clk),
    .rstN(rstN),
    .asyncIn({sckIn, csNIn, mosiIn}),
    .syncOut(syncVec)
  );

  spi_bridge_ctrl #(
    .HALF_W(HALF_W),
    .DATA_W(DATA_W)
  ) uCtrl (
    .clk(clk),
    .rstN(rstN),
    .sckSync(syncVec[2]),
    .csNSync(syncVec[1]),
    .cmdNow(cmdNow),
    .cmdHeld(cmdHeld),
    .strobes(strobes)
  );

  spi_bridge_dp #(
    .HALF_W(HALF_W),
    .DATA_W(DATA_W)
  ) uDp (
    .clk(clk),
    .rstN(rstN),
    .strobes(strobes),
    .mosiBit(syncVec[0]),
    .rdData(regRdata),
    .cmdNow(cmdNow),
    .cmdHeld(cmdHeld),
    .regAddr(regAddr),
    .regWdata(regWdata),
    .misoOut(misoOut)
  );

  assign regWr = strobes.wrStb;
  assign regRd = strobes.rdStb;

endmodule

// File: tb/tb_spi_reg_bridge.sv
module tb_spi_reg_bridge;

  typedef struct {
    bit          isWr;
    logic [14:0] addr;
    logic [15:0] data;
  } expItemT;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sckIn = 1'b0;
  logic        csNIn = 1'b1;
  logic        mosiIn = 1'b0;
  logic        misoOut;
  logic [14:0] regAddr;
  logic [15:0] regWdata;
  logic        regWr;
  logic        regRd;
  logic [15:0] regRdata = 16'h0;

  int checks = 0;
  int fails = 0;
  bit monOn = 1'b0;
  expItemT expQ[$];
  logic [15:0] devMem [logic [14:0]];   // register file model at the bus
  logic [15:0] shadow [logic [14:0]];   // driver's own expectation

  always #2 clk = ~clk;

  spi_reg_bridge dut (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .csNIn(csNIn), .mosiIn(mosiIn),
    .misoOut(misoOut), .regAddr(regAddr), .regWdata(regWdata),
    .regWr(regWr), .regRd(regRd), .regRdata(regRdata)
  );

  function automatic logic [15:0] defVal(input logic [14:0] a);
    return {1'b1, a} ^ 16'h5A00;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Register file model and scoreboard monitor, mid-cycle.
  always @(negedge clk) begin
    if (monOn && (regWr || regRd)) begin
      chk(!(regWr && regRd), "R3 strobes exclusive", {regWr, regRd}, 0);
      if (expQ.size() == 0) begin
        chk(1'b0, "R8 unexpected bus strobe", {regWr, regRd, regAddr}, 0);
      end else begin
        expItemT e;
        e = expQ.pop_front();
        chk(regWr == e.isWr, "R2/R3 strobe kind", regWr, e.isWr);
        chk(regAddr == e.addr, "R1 address", regAddr, e.addr);
        if (regWr) chk(regWdata == e.data, "R2 write data", regWdata, e.data);
      end
    end
    if (regWr) devMem[regAddr] = regWdata;
    if (regRd) regRdata = devMem.exists(regAddr) ? devMem[regAddr] : defVal(regAddr);
  end

  task automatic spiFrame(input logic [31:0] word, input int nBits,
                          output logic [15:0] hdrMiso, output logic [15:0] datMiso);
    hdrMiso = '0;
    datMiso = '0;
    @(negedge clk);
    csNIn = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < nBits; i++) begin
      sckIn = 1'b1;
      mosiIn = (i < 32) ? word[31-i] : 1'b1;
      repeat (2) @(negedge clk);
      if (i < 16) hdrMiso[15-i] = misoOut;
      else if (i < 32) datMiso[31-i] = misoOut;
      sckIn = 1'b0;
      repeat (2) @(negedge clk);
    end
    csNIn = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic doWrite(input logic [14:0] a, input logic [15:0] d, input int nBits);
    logic [15:0] h, m;
    expQ.push_back('{isWr: 1'b1, addr: a, data: d});
    shadow[a] = d;
    spiFrame({1'b0, a, d}, nBits, h, m);
    chk(h == 16'h0 && m == 16'h0, "R5 miso quiet in write frame", {h, m}, 0);
  endtask

  task automatic doRead(input logic [14:0] a, input logic [15:0] junk);
    logic [15:0] h, m, ev;
    ev = shadow.exists(a) ? shadow[a] : defVal(a);
    expQ.push_back('{isWr: 1'b0, addr: a, data: 16'h0});
    spiFrame({1'b1, a, junk}, 32, h, m);
    chk(h == 16'h0, "R5 miso zero in header", h, 0);
    chk(m == ev, "R4 read data", m, ev);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin : mainSeq
    logic [15:0] h, m;
    repeat (3) @(negedge clk);
    chk(regWr == 1'b0 && regRd == 1'b0, "R9 reset strobes", {regWr, regRd}, 0);
    chk(misoOut == 1'b0, "R9 reset miso", misoOut, 0);
    rstN = 1'b1;
    monOn = 1'b1;
    repeat (4) @(negedge clk);

    // R1 R2: plain writes, boundary addresses and data
    doWrite(15'h0012, 16'hBEEF, 32);
    doWrite(15'h7FFF, 16'h8001, 32);
    doWrite(15'h0000, 16'hFFFF, 32);

    // R3 R4: reads, including one that carries a nonzero data half
    doRead(15'h0012, 16'h0000);
    doRead(15'h7FFF, 16'hFFFF);
    doRead(15'h0000, 16'h1234);
    doRead(15'h1234, 16'h0000);
    doRead(15'h7FFF, 16'h0000);  // R3: previous read did not write

    // R6: aborted writes leave the registers unchanged
    spiFrame({1'b0, 15'h0012, 16'h1111}, 20, h, m);
    spiFrame({1'b0, 15'h7FFF, 16'h0000}, 31, h, m);
    doRead(15'h0012, 16'h0000);
    doRead(15'h7FFF, 16'h0000);

    // R5 R7: read aborted just after its fetch lands, then a fresh frame
    expQ.push_back('{isWr: 1'b0, addr: 15'h0012, data: 16'h0});
    spiFrame({1'b1, 15'h0012, 16'h0000}, 17, h, m);
    chk(misoOut == 1'b0, "R5 miso low after abort", misoOut, 0);
    doWrite(15'h0055, 16'h1357, 32);
    doRead(15'h0055, 16'h0000);

    // R8: serial clock activity with select high
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); sckIn = 1'b1; mosiIn = k[0];
      repeat (2) @(negedge clk); sckIn = 1'b0;
      @(negedge clk);
    end
    chk(misoOut == 1'b0, "R5 miso low while deselected", misoOut, 0);
    doWrite(15'h0042, 16'hA5A5, 32);

    // R8: extra edges past the 32nd bit
    doWrite(15'h0043, 16'h5A5A, 36);
    doRead(15'h0042, 16'h0000);
    doRead(15'h0043, 16'h0000);

    repeat (10) @(negedge clk);
    chk(expQ.size() == 0, "R3 all expected strobes seen", expQ.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule